// File: doc/BRIEF.md
# Scatter-Gather Audio DMA Channel

This block is one DMA channel for an audio subsystem. It walks a table of eight-byte descriptors in memory and moves sample words between each described buffer and a sample stream. Each descriptor holds a 32-bit buffer address at offset 0 and a 32-bit flags/count word at offset 4. Descriptors sit back to back from a base address that software programs before starting the channel.

Software sets up the channel through a four-entry register bus: a control register, a status register, the table base and a read-only position register. Per-descriptor marks in the flags word raise status events and optional interrupts at chosen segment ends and at the end of the list. A descriptor can pause the channel after its segment. An autostart mode loops back to the table head so that a ring of buffers plays without software help. One control bit picks the direction. In playback the channel reads words from memory and presents them on the sample output. In capture it writes the sample input into memory.

The memory port is always ready and returns read data one cycle after a request. One 32-bit word moves per beat, and the remaining byte count drops by 4 each beat. Segment byte counts are taken as multiples of 4.

Top module: `sgd_dma_chan`

## Requirements
- R1: After reset, control, status, base and position all read 0, `irq` is low and `mem_req` is low.
- R2: The descriptor at table index k is fetched as a pointer word from base+8k, then a flags word from base+8k+4. In the flags word, bit 31 marks end of list, bit 30 marks a flag point, bit 29 marks stop, and bits 23:0 give the byte count. In playback the buffer words are read at ascending word addresses from the pointer. Each word appears on `snd_data_out` with `snd_beat` high, one word per beat.
- R3: Register address 3 returns the index of the last completed segment in bits 31:24 and the bytes still to move in the current segment in bits 23:0. After a segment ends, bits 23:0 read 0.
- R4: Status (address 1) has these bits: bit 0 end-of-list seen, bit 1 flag seen, bit 2 active (read-only), bit 3 interrupt pending. Bits 0 and 1 are set when a segment carrying the matching mark completes. Writing 1 to either bit clears that bit only.
- R5: Interrupt pending sets only on a completed end-of-list segment with control bit 2 set, or a completed flag segment with control bit 3 set. `irq` follows it. Writing 1 to status bit 3 clears it.
- R6: When a status event and a write-one clear of the same bit land on the same clock edge, the bit stays set.
- R7: With autostart (control bit 1) clear, completing the end-of-list segment drops active and the channel idles.
- R8: With autostart set, the channel refetches from the base address after the end-of-list segment and stays active, so the same data repeats.
- R9: A descriptor with its stop bit set pauses the channel after its segment: active is 0 and no data moves. Writing start (control bit 0) again resumes with the next descriptor.
- R10: Writing control with bit 7 (stop) set halts the channel at once. A following write of 0 leaves it idle with no data movement.
- R11: With control bit 4 set, each beat writes `snd_data_in` to the next buffer word in ascending order, and words past the count stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 base, 3 position |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (capture data beat) |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| snd_data_in | input | 32 | Capture sample word |
| snd_data_out | output | 32 | Playback sample word |
| snd_beat | output | 1 | A sample word moves this cycle |
| irq | output | 1 | Interrupt pending |

## Verification
The two functions that can meet on one clock edge are a segment-completion event, which sets the end-of-list, flag and interrupt-pending bits, and a software write that clears those same bits. The bench provokes this by counting edges from the start write: 4 edges of descriptor fetch plus one edge per data word. It places a status write of 0x0B on exactly the completion edge. The result is judged by reading status afterwards and requiring all three bits still set with `irq` high, and then by checking that a clear one cycle later does empty them.

// File: rtl/sgd_dma_chan.sv
module sgd_dma_chan #(
  parameter int IDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic [31:0] snd_data_in,
  output logic [31:0] snd_data_out,
  output logic        snd_beat,
  output logic        irq
);
  localparam int CNT_W = 32 - IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_PTR, S_FLG, S_LATCH, S_DATA, S_PAUSE} st_t;
  st_t st;

  logic [31:0]      base, cur_desc, buf_ptr;
  logic [CNT_W-1:0] remain;
  logic [IDX_W-1:0] cur_idx, done_idx;
  logic             m_eol, m_flg, m_stop;
  logic             c_auto, c_ieeol, c_ieflg, c_cap;
  logic             s_eol, s_flg, s_int, beat_q;

  wire ctl_wr  = reg_wr && reg_addr == 2'd0;
  wire sts_wr  = reg_wr && reg_addr == 2'd1;
  wire go      = ctl_wr && reg_wdata[0] && !reg_wdata[7];
  wire halt    = ctl_wr && reg_wdata[7];
  wire moving  = st == S_DATA && remain != '0;
  wire seg_end = st == S_DATA && remain == '0;
  wire ev_eol  = seg_end && m_eol;
  wire ev_flg  = seg_end && m_flg;
  wire active  = st != S_IDLE && st != S_PAUSE;

  logic unused_flag_bits;
  assign unused_flag_bits = &{1'b0, mem_rdata[28:CNT_W]};

  assign mem_req      = st == S_PTR || st == S_FLG || moving;
  assign mem_we       = moving && c_cap;
  assign mem_addr     = st == S_PTR ? cur_desc : st == S_FLG ? cur_desc + 32'd4 : buf_ptr;
  assign mem_wdata    = snd_data_in;
  assign snd_data_out = mem_rdata;
  assign snd_beat     = c_cap ? mem_we : beat_q;
  assign irq          = s_int;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {27'd0, c_cap, c_ieflg, c_ieeol, c_auto, 1'b0};
      2'd1:    reg_rdata = {28'd0, s_int, active, s_flg, s_eol};
      2'd2:    reg_rdata = base;
      default: reg_rdata = {done_idx, remain};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {c_auto, c_ieeol, c_ieflg, c_cap} <= '0;
      base <= '0;
    end else begin
      if (ctl_wr) {c_cap, c_ieflg, c_ieeol, c_auto} <= reg_wdata[4:1];
      if (reg_wr && reg_addr == 2'd2) base <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s_eol, s_flg, s_int} <= '0;
    end else begin
      s_eol <= ev_eol | (s_eol & ~(sts_wr & reg_wdata[0]));
      s_flg <= ev_flg | (s_flg & ~(sts_wr & reg_wdata[1]));
      s_int <= (ev_eol & c_ieeol) | (ev_flg & c_ieflg) | (s_int & ~(sts_wr & reg_wdata[3]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur_desc <= '0;
      buf_ptr <= '0;
      remain <= '0;
      cur_idx <= '0;
      done_idx <= '0;
      {m_eol, m_flg, m_stop} <= '0;
      beat_q <= 1'b0;
    end else if (halt) begin
      st <= S_IDLE;
      beat_q <= 1'b0;
    end else begin
      beat_q <= moving && !c_cap;
      case (st)
        S_IDLE: if (go) begin
          cur_desc <= base;
          cur_idx <= '0;
          st <= S_PTR;
        end
        S_PAUSE: if (go) st <= S_PTR;
        S_PTR: st <= S_FLG;
        S_FLG: begin
          buf_ptr <= mem_rdata;
          st <= S_LATCH;
        end
        S_LATCH: begin
          remain <= mem_rdata[CNT_W-1:0];
          {m_eol, m_flg, m_stop} <= mem_rdata[31:29];
          st <= S_DATA;
        end
        S_DATA: if (moving) begin
          buf_ptr <= buf_ptr + 32'd4;
          remain <= remain >= CNT_W'(4) ? remain - CNT_W'(4) : '0;
        end else begin
          done_idx <= cur_idx;
          if (m_eol) begin
            cur_desc <= base;
            cur_idx <= '0;
            st <= c_auto ? S_PTR : S_IDLE;
          end else begin
            cur_desc <= cur_desc + 32'd8;
            cur_idx <= cur_idx + 1'b1;
            st <= m_stop ? S_PAUSE : S_PTR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (moving && !halt && remain >= CNT_W'(4)) |=> remain == $past(remain) - CNT_W'(4));

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_eol || ev_flg));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_flg || ev_eol) |=> (s_flg || s_eol));

  // R7
  eol_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_eol && !c_auto && !halt) |=> !active && !mem_req);

  // R10
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!active && !mem_req && !snd_beat));
endmodule

// File: tb/tb_sgd_dma_chan.sv
module tb_sgd_dma_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, snd_data_out, snd_data_in;
  logic snd_beat, irq;

  always #2 clk = ~clk;

  sgd_dma_chan dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .snd_data_in(snd_data_in),
    .snd_data_out(snd_data_out), .snd_beat(snd_beat), .irq(irq)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] rd_q = '0;
  logic [7:0]  cap_cnt = '0;
  logic [31:0] beat_log [0:63];
  int beat_n = 0;
  int checks = 0;
  int errors = 0;

  assign mem_rdata   = rd_q;
  assign snd_data_in = 32'hA500_0000 | {24'd0, cap_cnt};

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else rd_q <= mem[mem_addr[11:2]];
    end
    if (snd_beat) begin
      cap_cnt <= cap_cnt + 8'd1;
      if (beat_n < 64) beat_log[beat_n] <= snd_data_out;
      beat_n <= beat_n + 1;
    end
  end

  function automatic logic [31:0] pat(input int byte_addr);
    return 32'h1000_0000 + byte_addr / 4;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(2'd1, s);
      if (!s[2]) break;
    end
  endtask

  task automatic put_desc(input int at, input logic [31:0] ptr, input logic [31:0] flags);
    mem[at/4]     = ptr;
    mem[at/4 + 1] = flags;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk(v == 0, "R1 register reset", v, 0);
    end
    chk(irq == 1'b0 && mem_req == 1'b0, "R1 irq/mem_req reset", {30'd0, irq, mem_req}, 0);
  endtask

  task automatic t_play();
    logic [31:0] v;
    int b0;
    put_desc(32'h100, 32'h400, 32'h4000_0008);
    put_desc(32'h108, 32'h500, 32'h8000_000C);
    wr(2'd2, 32'h100);
    b0 = beat_n;
    wr(2'd0, 32'h0D);
    wait_idle();
    chk(beat_n - b0 == 5, "R2 beat count", beat_n - b0, 5);
    chk(beat_log[b0] == pat(32'h400), "R2 word 0", beat_log[b0], pat(32'h400));
    chk(beat_log[b0+1] == pat(32'h404), "R2 word 1", beat_log[b0+1], pat(32'h404));
    chk(beat_log[b0+2] == pat(32'h500), "R2 word 2", beat_log[b0+2], pat(32'h500));
    chk(beat_log[b0+4] == pat(32'h508), "R2 word 4", beat_log[b0+4], pat(32'h508));
    rd(2'd1, v);
    chk(v == 32'hB, "R4 R7 status after list", v, 32'hB);
    chk(irq == 1'b1, "R5 irq raised", irq, 1);
    rd(2'd3, v);
    chk(v == 32'h0100_0000, "R3 position", v, 32'h0100_0000);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(2'd1, 32'h2);
    rd(2'd1, v);
    chk(v == 32'h9, "R4 clear flag only", v, 32'h9);
    wr(2'd1, 32'h9);
    rd(2'd1, v);
    chk(v == 32'h0, "R5 write-back clears", v, 0);
    chk(irq == 1'b0, "R5 irq cleared", irq, 0);
  endtask

  task automatic t_noint();
    logic [31:0] v;
    wr(2'd0, 32'h01);
    wait_idle();
    rd(2'd1, v);
    chk(v == 32'h3, "R5 no interrupt when disabled", v, 32'h3);
    chk(irq == 1'b0, "R5 irq stays low", irq, 0);
    wr(2'd1, 32'hB);
  endtask

  task automatic t_same();
    logic [31:0] v;
    put_desc(32'h110, 32'h600, 32'hC000_0008);
    wr(2'd2, 32'h110);
    wr(2'd0, 32'h0D);
    repeat (4) @(negedge clk);
    wr(2'd1, 32'hB);
    wait_idle();
    rd(2'd1, v);
    chk(v == 32'hB, "R6 set beats clear in same cycle", v, 32'hB);
    chk(irq == 1'b1, "R6 irq kept", irq, 1);
    wr(2'd1, 32'hB);
    rd(2'd1, v);
    chk(v == 32'h0, "R6 later clear works", v, 0);
  endtask

  task automatic t_auto();
    logic [31:0] v;
    int b0, b1;
    wr(2'd2, 32'h100);
    b0 = beat_n;
    wr(2'd0, 32'h03);
    for (int i = 0; i < 200 && beat_n - b0 < 12; i++) @(negedge clk);
    rd(2'd1, v);
    chk(v[2] && v[0], "R8 active after looping", v, 32'h5);
    chk(beat_log[b0+5] == pat(32'h400), "R8 restart word 0", beat_log[b0+5], pat(32'h400));
    chk(beat_log[b0+9] == pat(32'h508), "R8 restart word 4", beat_log[b0+9], pat(32'h508));
    wr(2'd0, 32'h80);
    rd(2'd1, v);
    chk(v[2] == 1'b0, "R10 stop halts", v, 0);
    wr(2'd0, 32'h00);
    b1 = beat_n;
    repeat (12) @(negedge clk);
    rd(2'd1, v);
    chk(v[2] == 1'b0 && beat_n == b1, "R10 stays idle", beat_n - b1, 0);
    wr(2'd1, 32'hB);
  endtask

  task automatic t_stopdesc();
    logic [31:0] v;
    int b0;
    put_desc(32'h120, 32'h400, 32'h2000_0008);
    put_desc(32'h128, 32'h500, 32'h8000_0004);
    wr(2'd2, 32'h120);
    b0 = beat_n;
    wr(2'd0, 32'h01);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(beat_n - b0 == 2, "R9 paused after stop segment", beat_n - b0, 2);
    rd(2'd3, v);
    chk(v == 32'h0, "R9 R3 position at pause", v, 0);
    wr(2'd0, 32'h01);
    wait_idle();
    chk(beat_n - b0 == 3, "R9 resumed one more word", beat_n - b0, 3);
    chk(beat_log[b0+2] == pat(32'h500), "R9 resumed next descriptor", beat_log[b0+2], pat(32'h500));
    rd(2'd3, v);
    chk(v == 32'h0100_0000, "R9 R3 position after resume", v, 32'h0100_0000);
    wr(2'd1, 32'hB);
  endtask

  task automatic t_cap();
    logic [7:0] c0;
    put_desc(32'h130, 32'h700, 32'h8000_000C);
    wr(2'd2, 32'h130);
    c0 = cap_cnt;
    wr(2'd0, 32'h11);
    wait_idle();
    for (int k = 0; k < 3; k++)
      chk(mem[32'h700/4 + k] == (32'hA500_0000 | {24'd0, 8'(c0 + k)}), "R11 captured word",
          mem[32'h700/4 + k], 32'hA500_0000 | {24'd0, 8'(c0 + k)});
    chk(mem[32'h700/4 + 3] == pat(32'h70C), "R11 word past count kept", mem[32'h700/4 + 3], pat(32'h70C));
    wr(2'd0, 32'h00);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h1000_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_play();
    t_w1c();
    t_noint();
    t_same();
    t_auto();
    t_stopdesc();
    t_cap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule